// File: doc/BRIEF.md
# Time-of-Day Counter with Interval and Alarm Interrupts

This block keeps the time of day as three counters: a half-second count, a minute count and an hour count. It advances on a one-cycle 2 Hz tick pulse that is generated elsewhere from the system clock. The half-second count runs from 0 to 119 and then carries into the minutes. Minutes carry into hours at 60, and hours return to zero at 24.

Software can overwrite all three fields at once and can read them back continuously. It also programs a three-field alarm and picks one of five periodic interrupt rates.

The block drives two interrupt outputs. The interval interrupt pulses once per selected period: each half second, each second, each minute, each hour or each day. The alarm interrupt pulses once, on the tick that moves the time onto the programmed alarm value.

Top module: `rtc_alarm_top`

## Requirements
- R1: While `rst` is high at a clock edge, the three time fields are cleared to zero, both interrupt outputs go low and the alarm fields are cleared to zero.
- R2: A clock edge with `tick_i` high and `load_i` low adds one to `half_o`. From 119 it goes to 0 and `min_o` goes up by one.
- R3: `min_o` goes from 59 to 0 and carries into `hour_o`. `hour_o` goes from 23 to 0, so 23:59:119 becomes 0:0:0 on one tick.
- R4: With `tick_i` and `load_i` both low, the time fields keep their values and both interrupt outputs stay low.
- R5: With `load_i` high, the next edge stores `load_half_i`, `load_min_i` and `load_hour_i`. A tick in that cycle is ignored: it does not advance the time and raises no interrupt.
- R6: `iv_sel_i` picks the interval period:
  - 0: every tick.
  - 1: one second, i.e. each tick whose new `half_o` is even.
  - 2: one minute, i.e. each wrap of `half_o`.
  - 3: one hour, i.e. each wrap of `min_o`.
  - 4: one day, i.e. each wrap of `hour_o`.
  - 5 to 7: never.
  
  `irq_interval_o` is a one-cycle pulse in the cycle after the tick, alongside the updated time.
- R7: `alarm_wr_i` high stores `alarm_half_i`, `alarm_min_i` and `alarm_hour_i` at the edge. `irq_alarm_o` pulses for one cycle after a tick that makes all three time fields equal to the stored alarm. The compare uses the alarm value held before any write in that same cycle.
- R8: The alarm fires only on a tick transition. Writing an alarm equal to the current time, holding the time equal to the alarm, or loading the time onto the alarm raises no alarm pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 2 Hz time base pulse |
| load_i | input | 1 | Time load strobe |
| load_half_i | input | 7 | Half-second value to load |
| load_min_i | input | 6 | Minute value to load |
| load_hour_i | input | 5 | Hour value to load |
| alarm_wr_i | input | 1 | Alarm write strobe |
| alarm_half_i | input | 7 | Alarm half-second field |
| alarm_min_i | input | 6 | Alarm minute field |
| alarm_hour_i | input | 5 | Alarm hour field |
| iv_sel_i | input | 3 | Interval period select |
| half_o | output | 7 | Current half-second count |
| min_o | output | 6 | Current minute count |
| hour_o | output | 5 | Current hour count |
| irq_interval_o | output | 1 | Interval interrupt pulse |
| irq_alarm_o | output | 1 | Alarm interrupt pulse |

## Verification
A wrong count or a missed carry shows up on the time outputs in the cycle after the offending tick. So the checks compare all three fields after every driven cycle, and concentrate on the cycles at 119, 59 and 23.

A wrong alarm register or a wrong compare timing shows up later, only when the time reaches the alarm. It then appears as a missing pulse, an early pulse or a repeated pulse. For that reason the alarm is armed a few ticks ahead and then walked onto. It is also written equal to the present time, and the time is loaded onto it.

Interval decode faults appear on the first tick of the affected period. Each select code is therefore exercised across the boundary it marks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    IV_HALF = 3'd0,
    IV_SEC  = 3'd1,
    IV_MIN  = 3'd2,
    IV_HOUR = 3'd3,
    IV_DAY  = 3'd4
  } iv_sel_e;

endpackage

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
  parameter int MAX = 60,
  parameter int W   = $clog2(MAX)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] LAST = W'(MAX - 1);

  logic [W-1:0] cnt_q;

  // Out-of-range values (only possible after a load) wrap on the next step.
  assign wrap_o = step && (cnt_q >= LAST);

  always_comb begin
    if (ld)          nxt_o = ld_val;
    else if (wrap_o) nxt_o = '0;
    else if (step)   nxt_o = cnt_q + 1'b1;
    else             nxt_o = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_interval_gen.sv
module rtc_interval_gen
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       half_lsb,
  input  logic       wrap_half,
  input  logic       wrap_min,
  input  logic       wrap_hour,
  input  logic [2:0] sel,
  output logic       irq_o
);

  logic hit;

  always_comb begin
    case (iv_sel_e'(sel))
      IV_HALF: hit = step;
      IV_SEC:  hit = step && half_lsb;   // odd count steps to an even one
      IV_MIN:  hit = wrap_half;
      IV_HOUR: hit = wrap_min;
      IV_DAY:  hit = wrap_hour;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= hit;
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int HW  = 7,
  parameter int MW  = 6,
  parameter int HRW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [HW-1:0]  al_half,
  input  logic [MW-1:0]  al_min,
  input  logic [HRW-1:0] al_hour,
  input  logic           step,
  input  logic [HW-1:0]  nxt_half,
  input  logic [MW-1:0]  nxt_min,
  input  logic [HRW-1:0] nxt_hour,
  output logic           irq_o
);

  localparam int TW = HW + MW + HRW;

  logic [TW-1:0] al_q;
  logic [TW-1:0] nxt_time;

  assign nxt_time = {nxt_hour, nxt_min, nxt_half};

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      // Only a tick transition can raise the alarm; the old alarm value is used.
      irq_o <= step && (nxt_time == al_q);
      if (wr) al_q <= {al_hour, al_min, al_half};
    end
  end

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top #(
  parameter int HALF_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick_i,
  input  logic                            load_i,
  input  logic [$clog2(HALF_PER_MIN)-1:0] load_half_i,
  input  logic [$clog2(MIN_PER_HOUR)-1:0] load_min_i,
  input  logic [$clog2(HOUR_PER_DAY)-1:0] load_hour_i,
  input  logic                            alarm_wr_i,
  input  logic [$clog2(HALF_PER_MIN)-1:0] alarm_half_i,
  input  logic [$clog2(MIN_PER_HOUR)-1:0] alarm_min_i,
  input  logic [$clog2(HOUR_PER_DAY)-1:0] alarm_hour_i,
  input  logic [2:0]                      iv_sel_i,
  output logic [$clog2(HALF_PER_MIN)-1:0] half_o,
  output logic [$clog2(MIN_PER_HOUR)-1:0] min_o,
  output logic [$clog2(HOUR_PER_DAY)-1:0] hour_o,
  output logic                            irq_interval_o,
  output logic                            irq_alarm_o
);

  localparam int HW  = $clog2(HALF_PER_MIN);
  localparam int MW  = $clog2(MIN_PER_HOUR);
  localparam int HRW = $clog2(HOUR_PER_DAY);

  logic           step_half;
  logic           wrap_half, wrap_min, wrap_hour;
  logic [HW-1:0]  nxt_half;
  logic [MW-1:0]  nxt_min;
  logic [HRW-1:0] nxt_hour;

  // A load wins over the tick of the same cycle.
  assign step_half = tick_i && !load_i;

  rtc_wrap_counter #(.MAX(HALF_PER_MIN), .W(HW)) u_half (
    .clk(clk), .rst(rst), .ld(load_i), .ld_val(load_half_i), .step(step_half),
    .cnt_o(half_o), .nxt_o(nxt_half), .wrap_o(wrap_half)
  );

  rtc_wrap_counter #(.MAX(MIN_PER_HOUR), .W(MW)) u_min (
    .clk(clk), .rst(rst), .ld(load_i), .ld_val(load_min_i), .step(wrap_half),
    .cnt_o(min_o), .nxt_o(nxt_min), .wrap_o(wrap_min)
  );

  rtc_wrap_counter #(.MAX(HOUR_PER_DAY), .W(HRW)) u_hour (
    .clk(clk), .rst(rst), .ld(load_i), .ld_val(load_hour_i), .step(wrap_min),
    .cnt_o(hour_o), .nxt_o(nxt_hour), .wrap_o(wrap_hour)
  );

  rtc_interval_gen u_iv (
    .clk(clk), .rst(rst), .step(step_half), .half_lsb(half_o[0]),
    .wrap_half(wrap_half), .wrap_min(wrap_min), .wrap_hour(wrap_hour),
    .sel(iv_sel_i), .irq_o(irq_interval_o)
  );

  rtc_alarm_match #(.HW(HW), .MW(MW), .HRW(HRW)) u_alarm (
    .clk(clk), .rst(rst), .wr(alarm_wr_i),
    .al_half(alarm_half_i), .al_min(alarm_min_i), .al_hour(alarm_hour_i),
    .step(step_half), .nxt_half(nxt_half), .nxt_min(nxt_min), .nxt_hour(nxt_hour),
    .irq_o(irq_alarm_o)
  );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int HALF_PER_MIN = 120,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOUR_PER_DAY = 24
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            tick_i,
  input logic                            load_i,
  input logic [$clog2(HALF_PER_MIN)-1:0] load_half_i,
  input logic [$clog2(MIN_PER_HOUR)-1:0] load_min_i,
  input logic [$clog2(HOUR_PER_DAY)-1:0] load_hour_i,
  input logic [2:0]                      iv_sel_i,
  input logic [$clog2(HALF_PER_MIN)-1:0] half_o,
  input logic [$clog2(MIN_PER_HOUR)-1:0] min_o,
  input logic [$clog2(HOUR_PER_DAY)-1:0] hour_o,
  input logic                            irq_interval_o,
  input logic                            irq_alarm_o
);

  localparam int HW  = $clog2(HALF_PER_MIN);
  localparam int MW  = $clog2(MIN_PER_HOUR);
  localparam int HRW = $clog2(HOUR_PER_DAY);
  localparam logic [HW-1:0]  H_LAST  = HW'(HALF_PER_MIN - 1);
  localparam logic [MW-1:0]  M_LAST  = MW'(MIN_PER_HOUR - 1);
  localparam logic [HRW-1:0] HR_LAST = HRW'(HOUR_PER_DAY - 1);

  p_half_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && half_o < H_LAST) |=>
      (half_o == $past(half_o) + 1'b1) && $stable(min_o) && $stable(hour_o));

  p_day_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && half_o == H_LAST && min_o == M_LAST && hour_o == HR_LAST) |=>
      (half_o == '0) && (min_o == '0) && (hour_o == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=>
      $stable(half_o) && $stable(min_o) && $stable(hour_o) && !irq_interval_o && !irq_alarm_o);

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (half_o == $past(load_half_i)) && (min_o == $past(load_min_i)) &&
               (hour_o == $past(load_hour_i)) && !irq_interval_o && !irq_alarm_o);

  p_every_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && iv_sel_i == 3'd0) |=> irq_interval_o);

  p_alarm_src_r7: assert property (@(posedge clk) disable iff (rst)
    irq_alarm_o |-> $past(tick_i && !load_i));

  p_alarm_once_r8: assert property (@(posedge clk) disable iff (rst)
    irq_alarm_o |=> !irq_alarm_o);

endmodule

bind rtc_alarm_top rtc_alarm_chk #(
  .HALF_PER_MIN(HALF_PER_MIN), .MIN_PER_HOUR(MIN_PER_HOUR), .HOUR_PER_DAY(HOUR_PER_DAY)
) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
  .load_half_i(load_half_i), .load_min_i(load_min_i), .load_hour_i(load_hour_i),
  .iv_sel_i(iv_sel_i), .half_o(half_o), .min_o(min_o), .hour_o(hour_o),
  .irq_interval_o(irq_interval_o), .irq_alarm_o(irq_alarm_o)
);

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0, load_i = 1'b0, alarm_wr_i = 1'b0;
  logic [6:0] load_half_i = '0, alarm_half_i = '0;
  logic [5:0] load_min_i = '0, alarm_min_i = '0;
  logic [4:0] load_hour_i = '0, alarm_hour_i = '0;
  logic [2:0] iv_sel_i = '0;
  logic [6:0] half_o;
  logic [5:0] min_o;
  logic [4:0] hour_o;
  logic       irq_interval_o, irq_alarm_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [6:0] h;
    logic [5:0] m;
    logic [4:0] hr;
    logic       ii;
    logic       ia;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;

  // Reference model state
  int m_h = 0, m_m = 0, m_hr = 0;
  int a_h = 0, a_m = 0, a_hr = 0;

  always #4 clk = ~clk;

  rtc_alarm_top dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .load_half_i(load_half_i), .load_min_i(load_min_i), .load_hour_i(load_hour_i),
    .alarm_wr_i(alarm_wr_i), .alarm_half_i(alarm_half_i), .alarm_min_i(alarm_min_i),
    .alarm_hour_i(alarm_hour_i), .iv_sel_i(iv_sel_i),
    .half_o(half_o), .min_o(min_o), .hour_o(hour_o),
    .irq_interval_o(irq_interval_o), .irq_alarm_o(irq_alarm_o)
  );

  // Driver: one call drives one cycle and queues the expected result.
  task automatic drive(input bit tk, input bit ld, input int lh, input int lm, input int lhr,
                       input bit aw, input int ah, input int am, input int ahr,
                       input int sel, input string tag);
    exp_t e;
    bit wh, wm, wd, ii, ia;
    @(negedge clk);
    tick_i = tk; load_i = ld; alarm_wr_i = aw; iv_sel_i = 3'(sel);
    load_half_i = 7'(lh); load_min_i = 6'(lm); load_hour_i = 5'(lhr);
    alarm_half_i = 7'(ah); alarm_min_i = 6'(am); alarm_hour_i = 5'(ahr);
    ii = 1'b0; ia = 1'b0;
    if (ld) begin
      m_h = lh; m_m = lm; m_hr = lhr;
    end else if (tk) begin
      wh = (m_h >= 119); wm = wh && (m_m >= 59); wd = wm && (m_hr >= 23);
      case (sel)
        0: ii = 1'b1;
        1: ii = (m_h % 2) == 1;
        2: ii = wh;
        3: ii = wm;
        4: ii = wd;
        default: ii = 1'b0;
      endcase
      m_h = wh ? 0 : m_h + 1;
      if (wh) m_m = wm ? 0 : m_m + 1;
      if (wm) m_hr = wd ? 0 : m_hr + 1;
      ia = (m_h == a_h) && (m_m == a_m) && (m_hr == a_hr);
    end
    if (aw) begin
      a_h = ah; a_m = am; a_hr = ahr;
    end
    e.h = 7'(m_h); e.m = 6'(m_m); e.hr = 5'(m_hr); e.ii = ii; e.ia = ia; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic tick_n(input int n, input int sel, input string tag);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, 0, sel, tag);
  endtask

  // Monitor: compares after each edge that has a queued expectation.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() != 0) begin
      mon_e = sb_q.pop_front();
      total++;
      if (half_o !== mon_e.h || min_o !== mon_e.m || hour_o !== mon_e.hr ||
          irq_interval_o !== mon_e.ii || irq_alarm_o !== mon_e.ia) begin
        bad++;
        $display("FAIL %s: actual h=%0d m=%0d hr=%0d iv=%0b al=%0b expected h=%0d m=%0d hr=%0d iv=%0b al=%0b",
                 mon_e.tag, half_o, min_o, hour_o, irq_interval_o, irq_alarm_o,
                 mon_e.h, mon_e.m, mon_e.hr, mon_e.ii, mon_e.ia);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible at the ports
    total++;
    if (half_o !== 0 || min_o !== 0 || hour_o !== 0 || irq_interval_o !== 0 || irq_alarm_o !== 0) begin
      bad++;
      $display("FAIL R1: actual h=%0d m=%0d hr=%0d iv=%0b al=%0b expected all zero",
               half_o, min_o, hour_o, irq_interval_o, irq_alarm_o);
    end

    tick_n(3, 0, "R2");                           // every-tick interval, count 1..3
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    tick_n(4, 1, "R6");                           // one-second interval
    tick_n(2, 5, "R6");                           // unused code: no interval
    drive(1, 1, 118, 59, 0, 0, 0, 0, 0, 0, "R5"); // load wins over tick
    tick_n(1, 2, "R2");                           // 118 -> 119
    tick_n(1, 3, "R3");                           // minute and hour carry, hourly irq
    drive(1, 1, 119, 59, 23, 0, 0, 0, 0, 4, "R5");
    tick_n(1, 4, "R3");                           // day wrap, daily irq
    tick_n(1, 4, "R6");                           // no daily irq on ordinary tick
    drive(0, 0, 0, 0, 0, 1, 5, 0, 0, 6, "R7");    // arm alarm at 0:0:5
    tick_n(4, 6, "R7");                           // reaches 5 on the 4th tick
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 6, "R8");    // stays equal: no repeat
    drive(0, 0, 0, 0, 0, 1, 5, 0, 0, 6, "R8");    // rewrite equal to current time
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 6, "R8");
    drive(0, 1, 4, 0, 0, 0, 0, 0, 0, 6, "R8");    // load to 4
    drive(0, 1, 5, 0, 0, 0, 0, 0, 0, 6, "R8");    // load onto alarm value: no pulse
    drive(1, 0, 0, 0, 0, 1, 6, 0, 0, 6, "R7");    // write 6 with tick to 6: old alarm used
    tick_n(1, 6, "R7");
    drive(1, 1, 5, 0, 0, 0, 0, 0, 0, 6, "R7");    // load to 5
    tick_n(1, 6, "R7");                           // to 6: new alarm fires

    repeat (3) @(negedge clk);
    tick_i = 0; load_i = 0; alarm_wr_i = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule